// File: doc/BRIEF.md
# Two-Pass Converter Phase Sequencer

This block is the clocked controller that orders the internal steps of a two-pass (coarse then fine) sampling analog-to-digital converter. An asynchronous start pulse is brought into the clock domain and reduced to a single rising-edge event. That event starts a fixed sequence. The input track/hold goes to hold, the coarse pass runs and its result is strobed, and the residue switches change over. The residue hold is then applied and the input track/hold returns to track, so acquisition of the next sample overlaps the fine pass. The fine result is strobed, the output latch is loaded, and after a guard interval the active-low busy flag is released.

Each phase length is given in nanoseconds and turned into a whole number of clock cycles from the clock frequency parameter, rounding up. The analog circuits are not part of the block. Only their control lines are produced here, each one straight from a flop.

Top module: `adc_phase_seq`

## Requirements
- R1: While reset is held and afterwards until a start event, busy_n is 1 and in_hold, res_hold, coarse_sw_en, fine_sw_en, coarse_strobe, fine_strobe and latch_load are all 0.
- R2: A rising edge on conv_start_a drives busy_n low at the third rising clock edge after the edge (two synchroniser flops plus the edge register), well within 100 ns at 250 MHz.
- R3: in_hold (1 = hold) rises together with the fall of busy_n and stays high for P1+1+S cycles. P1, S, P2 and L are the coarse, swap, fine and lead phase lengths in cycles, each ceil(ns*CLK_MHZ/1000) with a minimum of 1.
- R4: coarse_sw_en is high for the first P1+1 cycles of a conversion, and fine_sw_en is high for the following S+P2+1 cycles. The two are never high together.
- R5: coarse_strobe pulses exactly once, at cycle offset P1 from the fall of busy_n. fine_strobe pulses exactly once, at offset P1+S+P2+1.
- R6: res_hold is high for P2+1 cycles starting at offset P1+S+1, the same cycle in which in_hold returns to track. in_hold is never high while res_hold is high.
- R7: latch_load pulses exactly once, at offset P1+S+P2+2, and busy_n stays low for L further cycles after the load cycle.
- R8: busy_n stays low for exactly P1+S+P2+L+3 cycles per conversion. With defaults (250 MHz; 3350, 16, 1800, 40 ns) that is 838+4+450+10+3 = 1305 cycles.
- R9: A start edge that the synchroniser reports while busy_n is low is discarded, not queued. A start input held high never starts a second conversion. Only a fresh rising edge seen while idle starts one.
- R10: Reset applied in the middle of a conversion returns every output to the idle values of R1 at the next clock edge. The next start edge then runs a complete, normal conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_start_a | input | 1 | Asynchronous conversion start; the rising edge is the event |
| busy_n | output | 1 | Low from conversion start until the result is latched plus the lead interval |
| in_hold | output | 1 | Input track/hold control, 1 = hold, 0 = track |
| res_hold | output | 1 | Residue stage track/hold control, 1 = hold |
| coarse_sw_en | output | 1 | Enables the residue switch used during the coarse pass |
| fine_sw_en | output | 1 | Enables the residue switch used during the fine pass |
| coarse_strobe | output | 1 | One-cycle strobe: coarse result ready for the combiner |
| fine_strobe | output | 1 | One-cycle strobe: fine result ready for the combiner |
| latch_load | output | 1 | One-cycle load of the combined result into the output latch |

## Verification
The bench measures every conversion cycle by cycle against the offsets in the requirements. An off-by-one in the phase timer would move the strobes, the load and the busy length by a cycle. A design that released the input hold before the residue stage held would lose the sample, and a design that freed busy together with the latch load would break the data-before-busy margin. Start edges are injected in the middle of a conversion and three cycles before its end, where the synchronised edge reaches the state machine in its last busy cycle. A design that queued or honoured those edges would start a second conversion. A start line held high, a reset in the middle of a conversion and back-to-back conversions cover the remaining edge handling.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
// Package: shared state encoding and the ns-to-cycle conversion for the
// two-pass converter phase sequencer. Assumes phase lengths fit in 32 bits.
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_COARSE = 3'd1,
        ST_CSTB   = 3'd2,
        ST_SWAP   = 3'd3,
        ST_FINE   = 3'd4,
        ST_FSTB   = 3'd5,
        ST_LOAD   = 3'd6,
        ST_LEAD   = 3'd7
    } seq_state_e;

    // Round a duration in ns up to whole clock cycles, never below one.
    function automatic int ns_to_cycles(input int dur_ns, input int clk_mhz);
        int c;
        c = (dur_ns * clk_mhz + 999) / 1000;
        if (c < 1) c = 1;
        return c;
    endfunction

endpackage

// File: rtl/adc_seq_sync.sv
`timescale 1ns/1ps
// Start synchroniser: brings the asynchronous start line into the clock
// domain through STAGES flops and emits a one-cycle pulse on its rising edge.
// Assumes the start line is low when reset is released.
module adc_seq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_a,
    output logic rise_pulse
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Synchroniser chain; first stage samples the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= start_a;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // Further synchroniser stages.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    endgenerate

    // Delayed copy of the synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[STAGES-1];
    end

    assign rise_pulse = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/adc_seq_timer.sv
`timescale 1ns/1ps
// Phase timer: down-counter loaded with (length-1) on each phase entry.
// Flags expiry when the count reaches zero and then holds at zero.
module adc_seq_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Load on phase entry, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/adc_seq_fsm.sv
`timescale 1ns/1ps
// Phase state machine: steps through coarse pass, coarse strobe, switch
// swap, fine pass, fine strobe, latch load and busy lead. Starts only from
// idle, so start events during a conversion are dropped. Exposes the next
// state so the output stage can register decoded controls without latency.
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int P1_CYC = 838,
    parameter int SW_CYC = 4,
    parameter int P2_CYC = 450,
    parameter int LD_CYC = 10,
    parameter int CNT_W  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_evt,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output seq_state_e       state_nxt
);
    seq_state_e state_q;

    // Phase length in cycles for a given state.
    function automatic int phase_len(input seq_state_e s);
        case (s)
            ST_COARSE: return P1_CYC;
            ST_SWAP:   return SW_CYC;
            ST_FINE:   return P2_CYC;
            ST_LEAD:   return LD_CYC;
            default:   return 1;
        endcase
    endfunction

    // Successor in the fixed conversion order.
    function automatic seq_state_e succ(input seq_state_e s);
        case (s)
            ST_COARSE: return ST_CSTB;
            ST_CSTB:   return ST_SWAP;
            ST_SWAP:   return ST_FINE;
            ST_FINE:   return ST_FSTB;
            ST_FSTB:   return ST_LOAD;
            ST_LOAD:   return ST_LEAD;
            default:   return ST_IDLE;
        endcase
    endfunction

    // Next-state and timer-load decision.
    always_comb begin
        state_nxt = state_q;
        if (state_q == ST_IDLE) begin
            if (start_evt) state_nxt = ST_COARSE;
        end else if (tmr_expired) begin
            state_nxt = succ(state_q);
        end
        tmr_load = (state_nxt != state_q);
        tmr_val  = CNT_W'(phase_len(state_nxt) - 1);
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nxt;
    end

endmodule

// File: rtl/adc_seq_outdec.sv
`timescale 1ns/1ps
// Output stage: decodes the next state into the analog control lines and
// registers them, so every control leaves the block straight from a flop
// and changes in the same cycle as the state.
module adc_seq_outdec
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_e state_nxt,
    output logic       busy_n,
    output logic       in_hold,
    output logic       res_hold,
    output logic       coarse_sw_en,
    output logic       fine_sw_en,
    output logic       coarse_strobe,
    output logic       fine_strobe,
    output logic       latch_load
);
    logic busy_d, ihold_d, rhold_d, csw_d, fsw_d, cstb_d, fstb_d, load_d;

    // Control decode for the state about to be entered.
    always_comb begin
        busy_d  = (state_nxt != ST_IDLE);
        ihold_d = (state_nxt == ST_COARSE) || (state_nxt == ST_CSTB) ||
                  (state_nxt == ST_SWAP);
        csw_d   = (state_nxt == ST_COARSE) || (state_nxt == ST_CSTB);
        fsw_d   = (state_nxt == ST_SWAP) || (state_nxt == ST_FINE) ||
                  (state_nxt == ST_FSTB);
        rhold_d = (state_nxt == ST_FINE) || (state_nxt == ST_FSTB);
        cstb_d  = (state_nxt == ST_CSTB);
        fstb_d  = (state_nxt == ST_FSTB);
        load_d  = (state_nxt == ST_LOAD);
    end

    // Output registers with idle values in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_n        <= 1'b1;
            in_hold       <= 1'b0;
            res_hold      <= 1'b0;
            coarse_sw_en  <= 1'b0;
            fine_sw_en    <= 1'b0;
            coarse_strobe <= 1'b0;
            fine_strobe   <= 1'b0;
            latch_load    <= 1'b0;
        end else begin
            busy_n        <= ~busy_d;
            in_hold       <= ihold_d;
            res_hold      <= rhold_d;
            coarse_sw_en  <= csw_d;
            fine_sw_en    <= fsw_d;
            coarse_strobe <= cstb_d;
            fine_strobe   <= fstb_d;
            latch_load    <= load_d;
        end
    end

endmodule

// File: rtl/adc_phase_seq.sv
`timescale 1ns/1ps
// Top: phase sequencer for a two-pass sampling converter. Converts phase
// lengths given in ns into cycle counts at CLK_MHZ and wires synchroniser,
// timer, state machine and output stage. Assumes conv_start_a is low at
// reset release and that its pulses are wider than one clock period.
module adc_phase_seq
    import adc_seq_pkg::*;
#(
    parameter int CLK_MHZ     = 250,
    parameter int PASS1_NS    = 3350,
    parameter int SWAP_NS     = 16,
    parameter int PASS2_NS    = 1800,
    parameter int LEAD_NS     = 40,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_start_a,
    output logic busy_n,
    output logic in_hold,
    output logic res_hold,
    output logic coarse_sw_en,
    output logic fine_sw_en,
    output logic coarse_strobe,
    output logic fine_strobe,
    output logic latch_load
);
    localparam int P1_CYC  = ns_to_cycles(PASS1_NS, CLK_MHZ);
    localparam int SW_CYC  = ns_to_cycles(SWAP_NS,  CLK_MHZ);
    localparam int P2_CYC  = ns_to_cycles(PASS2_NS, CLK_MHZ);
    localparam int LD_CYC  = ns_to_cycles(LEAD_NS,  CLK_MHZ);
    localparam int MAX_A   = (P1_CYC > P2_CYC) ? P1_CYC : P2_CYC;
    localparam int MAX_B   = (SW_CYC > LD_CYC) ? SW_CYC : LD_CYC;
    localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic             start_evt;
    logic             tmr_expired;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    seq_state_e       state_nxt;

    adc_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_a    (conv_start_a),
        .rise_pulse (start_evt)
    );

    adc_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    adc_seq_fsm #(
        .P1_CYC (P1_CYC),
        .SW_CYC (SW_CYC),
        .P2_CYC (P2_CYC),
        .LD_CYC (LD_CYC),
        .CNT_W  (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_evt   (start_evt),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .state_nxt   (state_nxt)
    );

    adc_seq_outdec u_out (
        .clk           (clk),
        .rst_n         (rst_n),
        .state_nxt     (state_nxt),
        .busy_n        (busy_n),
        .in_hold       (in_hold),
        .res_hold      (res_hold),
        .coarse_sw_en  (coarse_sw_en),
        .fine_sw_en    (fine_sw_en),
        .coarse_strobe (coarse_strobe),
        .fine_strobe   (fine_strobe),
        .latch_load    (latch_load)
    );

endmodule

// File: rtl/adc_phase_seq_checker.sv
`timescale 1ns/1ps
// Checker: protocol properties on the sequencer outputs, bound to the top.
module adc_phase_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic busy_n,
    input logic in_hold,
    input logic res_hold,
    input logic coarse_sw_en,
    input logic fine_sw_en,
    input logic coarse_strobe,
    input logic fine_strobe,
    input logic latch_load
);
    // R1: idle means every control is released.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        busy_n |-> !(in_hold || res_hold || coarse_sw_en || fine_sw_en ||
                     coarse_strobe || fine_strobe || latch_load));

    // R3: conversion begins with the input in hold and the coarse switch on.
    p_start_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_n) |-> (in_hold && coarse_sw_en));

    // R4: the residue switches are never enabled together.
    p_sw_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(coarse_sw_en && fine_sw_en));

    // R5: strobes are single-cycle pulses.
    p_cstb_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        coarse_strobe |=> !coarse_strobe);
    p_fstb_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fine_strobe |=> !fine_strobe);

    // R6: input track/hold tracks whenever the residue stage holds.
    p_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_hold |-> !in_hold);

    // R6: residue hold is entered from the swap with the fine switch on.
    p_rhold_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_hold) |-> (fine_sw_en && $fell(in_hold)));

    // R7: latch load is a single pulse and busy stays low after it.
    p_load_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        latch_load |=> (!busy_n && !latch_load));

    // R7: busy is released only after the fine strobe has passed.
    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_n) |-> ($past(!fine_strobe) && $past(!latch_load)));

endmodule

bind adc_phase_seq adc_phase_seq_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy_n        (busy_n),
    .in_hold       (in_hold),
    .res_hold      (res_hold),
    .coarse_sw_en  (coarse_sw_en),
    .fine_sw_en    (fine_sw_en),
    .coarse_strobe (coarse_strobe),
    .fine_strobe   (fine_strobe),
    .latch_load    (latch_load)
);

// File: tb/adc_phase_seq_bench.sv
`timescale 1ns/1ps
// Directed bench for the phase sequencer: one task per scenario.
module adc_phase_seq_bench;

    // Expected phase lengths from the requirement formula, default params.
    function automatic int cyc(input int ns);
        int c;
        c = (ns * 250 + 999) / 1000;
        if (c < 1) c = 1;
        return c;
    endfunction

    localparam int P1  = cyc(3350);
    localparam int S   = cyc(16);
    localparam int P2  = cyc(1800);
    localparam int L   = cyc(40);
    localparam int TOT = P1 + S + P2 + L + 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_start_a = 1'b0;
    logic busy_n, in_hold, res_hold, coarse_sw_en, fine_sw_en;
    logic coarse_strobe, fine_strobe, latch_load;

    int n_tests = 0;
    int n_fail  = 0;

    // Per-conversion measurements.
    int lat, blen, n_ih, ih_fall, n_csw, n_fsw, n_cs, cs_k, n_fs, fs_k;
    int n_ld, ld_k, n_rh, rh_k, both_sw, ovl, retrig;

    always #2 clk = ~clk;

    adc_phase_seq u_adc_phase_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .conv_start_a  (conv_start_a),
        .busy_n        (busy_n),
        .in_hold       (in_hold),
        .res_hold      (res_hold),
        .coarse_sw_en  (coarse_sw_en),
        .fine_sw_en    (fine_sw_en),
        .coarse_strobe (coarse_strobe),
        .fine_strobe   (fine_strobe),
        .latch_load    (latch_load)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    function automatic int idle_bits();
        return {busy_n, in_hold, res_hold, coarse_sw_en, fine_sw_en,
                coarse_strobe, fine_strobe, latch_load};
    endfunction

    // Raise start, follow one conversion cycle by cycle, then watch 20 idle cycles.
    task automatic run_conv(input int drop_after, input int inj_at);
        int n;
        int k;
        @(negedge clk);
        conv_start_a = 1'b1;
        n = 0; lat = -1;
        while (lat < 0 && n < 10) begin
            @(negedge clk); n++;
            if (n == drop_after) conv_start_a = 1'b0;
            if (!busy_n) lat = n;
        end
        n_ih = 0; ih_fall = -1; n_csw = 0; n_fsw = 0; n_cs = 0; cs_k = -1;
        n_fs = 0; fs_k = -1; n_ld = 0; ld_k = -1; n_rh = 0; rh_k = -1;
        both_sw = 0; ovl = 0; retrig = 0;
        k = 0;
        while (!busy_n && k < 5000) begin
            if (in_hold) n_ih++;
            else if (ih_fall < 0) ih_fall = k;
            if (coarse_sw_en) n_csw++;
            if (fine_sw_en) n_fsw++;
            if (coarse_sw_en && fine_sw_en) both_sw++;
            if (coarse_strobe) begin n_cs++; cs_k = k; end
            if (fine_strobe) begin n_fs++; fs_k = k; end
            if (latch_load) begin n_ld++; ld_k = k; end
            if (res_hold) begin n_rh++; if (rh_k < 0) rh_k = k; end
            if (res_hold && in_hold) ovl++;
            if (k == inj_at) conv_start_a = 1'b1;
            if (inj_at >= 0 && k == inj_at + 13) conv_start_a = 1'b0;
            @(negedge clk); k++; n++;
            if (n == drop_after) conv_start_a = 1'b0;
        end
        blen = k;
        for (int i = 0; i < 20; i++) begin
            if (!busy_n) retrig = 1;
            if (inj_at >= 0 && k == inj_at + 13) conv_start_a = 1'b0;
            @(negedge clk); k++;
        end
        if (drop_after >= 0) conv_start_a = 1'b0;
    endtask

    task automatic check_timeline(input string tag);
        check(lat == 3, {"R2 start latency ", tag}, lat, 3);
        check(n_ih == P1 + 1 + S, {"R3 hold length ", tag}, n_ih, P1 + 1 + S);
        check(n_csw == P1 + 1, {"R4 coarse sw ", tag}, n_csw, P1 + 1);
        check(n_fsw == S + P2 + 1, {"R4 fine sw ", tag}, n_fsw, S + P2 + 1);
        check(both_sw == 0, {"R4 exclusive ", tag}, both_sw, 0);
        check(n_cs == 1 && cs_k == P1, {"R5 coarse strobe ", tag}, cs_k, P1);
        check(n_fs == 1 && fs_k == P1 + S + P2 + 1, {"R5 fine strobe ", tag}, fs_k, P1 + S + P2 + 1);
        check(n_rh == P2 + 1 && rh_k == P1 + S + 1 && ih_fall == rh_k,
              {"R6 residue hold ", tag}, rh_k, P1 + S + 1);
        check(ovl == 0, {"R6 overlap ", tag}, ovl, 0);
        check(n_ld == 1 && ld_k == P1 + S + P2 + 2, {"R7 latch load ", tag}, ld_k, P1 + S + P2 + 2);
        check(blen - ld_k - 1 == L, {"R7 lead ", tag}, blen - ld_k - 1, L);
        check(blen == TOT, {"R8 busy length ", tag}, blen, TOT);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; conv_start_a = 1'b0;
        repeat (4) @(negedge clk);
        check(idle_bits() == 8'h80, "R1 outputs in reset", idle_bits(), 8'h80);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check(idle_bits() == 8'h80, "R1 idle after reset", idle_bits(), 8'h80);
    endtask

    task automatic t_single();
        run_conv(13, -1);
        check_timeline("single");
        check(retrig == 0, "R9 no spurious restart", retrig, 0);
    endtask

    task automatic t_back2back();
        run_conv(13, -1);
        run_conv(13, -1);
        check_timeline("back-to-back");
    endtask

    task automatic t_ignore_mid();
        run_conv(13, 200);
        check(blen == TOT, "R9 mid edge busy length", blen, TOT);
        check(retrig == 0, "R9 mid edge not queued", retrig, 0);
    endtask

    task automatic t_ignore_end();
        run_conv(13, TOT - 3);
        check(blen == TOT, "R9 late edge busy length", blen, TOT);
        check(retrig == 0, "R9 late edge not queued", retrig, 0);
    endtask

    task automatic t_held();
        run_conv(-1, -1);
        check(blen == TOT, "R9 held start length", blen, TOT);
        check(retrig == 0, "R9 held start no retrigger", retrig, 0);
        conv_start_a = 1'b0;
        repeat (5) @(negedge clk);
        run_conv(13, -1);
        check_timeline("after held");
    endtask

    task automatic t_reset_mid();
        int r;
        @(negedge clk);
        conv_start_a = 1'b1;
        repeat (13) @(negedge clk);
        conv_start_a = 1'b0;
        repeat (P1 + S + 20) @(negedge clk);
        check(!busy_n && res_hold, "R10 mid conversion before reset", busy_n, 0);
        rst_n = 1'b0;
        @(negedge clk);
        check(idle_bits() == 8'h80, "R10 idle one edge into reset", idle_bits(), 8'h80);
        rst_n = 1'b1;
        r = 0;
        repeat (20) begin @(negedge clk); if (!busy_n) r = 1; end
        check(r == 0, "R10 no stale restart", r, 0);
        run_conv(13, -1);
        check_timeline("after reset");
    endtask

    initial begin
        t_reset();
        t_single();
        t_back2back();
        t_ignore_mid();
        t_ignore_end();
        t_held();
        t_reset_mid();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule